// File: doc/BRIEF.md
# Parallel-Bus SAR Converter Sequencer

This block is the digital core of a 10-bit successive-approximation converter that sits on a byte-wide microprocessor bus. The host selects the block with an active-low chip select. It writes an 8-bit control byte with an active-low write strobe, and that byte sets the channel, the input polarity, the acquisition style, the conversion clock source and the power state. The block then tracks the selected input, holds it, and runs a 10-step binary search. At each step it presents a trial code to the external capacitive DAC and reads back one comparator bit. When the search is done it pulls an active-low interrupt.

The host reads the result as two bytes, and a byte-select pin picks which one. The high byte carries the two top result bits. Its upper six bits are zero in unipolar mode and copies of the sign bit in bipolar mode. The bus is modelled as a data output plus an output enable, and the pad logic builds the tri-state driver from them. All activity is synchronous to one system clock. Conversion steps advance on a "tick", which comes either from falling edges of an external conversion clock pin or from a free-running internal divider.

Top module: `adcseq_top`

## Requirements
- R1: After reset, int_n is 1, ext_clk_mode is 1, pwr_state is 0 (on), track is 0, chan_sel is 0 and dout_en is 0 while rd_n is high.
- R2: A control byte is taken only on a cycle where wr_n is high, wr_n was low on the previous cycle and cs_n is low. A strobe given while cs_n is high leaves track, chan_sel and every other output unchanged.
- R3: Control byte bit 7 and bit 6 form the power code. Code 2'b10 selects the internal tick (ext_clk_mode=0) and 2'b11 selects the external tick (ext_clk_mode=1). Codes 2'b00 and 2'b01 leave ext_clk_mode as it was.
- R4: With bit 5 of the byte at 0, track is 1 from the cycle after the write. The conversion starts at the fourth tick after the write, and track returns to 0 there.
- R5: With bit 5 at 1, track stays 1 for as long as no further write arrives. A following write with bit 5 at 0 starts the conversion at once.
- R6: A conversion takes 13 ticks. int_n goes low in the cycle after the 13th tick.
- R7: On conversion ticks 1 to 10 the block decides result bits 9 down to 0 in turn. A trial bit is kept when cmp_in is 1. dac_code shows the current trial code, and it starts at 10'h200.
- R8: A write during acquisition or conversion abandons that work and starts over with the new byte.
- R9: int_n returns to 1 on a read start (rd_n falling while cs_n is low) or on an accepted write.
- R10: With hben=0 the bus carries result bits 7..0. With hben=1 it carries result bits 9..8 in bits 1..0, and bits 7..2 hold the fill.
- R11: When bit 3 of the byte is 1 (unipolar), the result is the raw code and the fill is 0. When bit 3 is 0 (bipolar), the result is the raw code with bit 9 inverted, which is two's complement, and the fill copies result bit 9.
- R12: dout_en is 1 only while cs_n and rd_n are both low. While cs_n is high, external ticks are ignored. The internal tick is one pulse every INT_DIV system clocks, counted from reset.
- R13: When a conversion ends, power code 00 sets pwr_state to 2 (full off) and 01 sets it to 1 (standby). Any accepted write sets pwr_state back to 0. Reads still work while powered down.
- R14: chan_sel copies byte bits 2..0, and diff_mode is the inverse of bit 4. pair_swap is 1 when diff_mode is 1 and bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| hben | input | 1 | Byte select for reads: 1 selects the high byte |
| din | input | 8 | Control byte from the bus |
| conv_clk | input | 1 | External conversion clock; ticks on its falling edges |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dout | output | 8 | Result byte for the bus |
| dout_en | output | 1 | Bus drive enable |
| int_n | output | 1 | Active-low result-ready interrupt |
| dac_code | output | 10 | Trial code for the capacitive DAC |
| track | output | 1 | Track/hold in track phase |
| chan_sel | output | 3 | Input multiplexer address |
| diff_mode | output | 1 | Pseudo-differential input selected |
| pair_swap | output | 1 | Swap the polarity of the differential pair |
| ext_clk_mode | output | 1 | External conversion tick selected |
| pwr_state | output | 2 | 0 on, 1 standby, 2 full off |

## Verification
A behavioural model runs beside the block on every clock, and the comparator is emulated by comparing a target code with dac_code. Several targets are used. A unipolar target tells a correct search apart from bit-order mistakes. A bipolar target below mid-scale catches a wrong sign fill or a missing MSB inversion. Both the internal and the external tick are exercised, so that tick counting is separated from the choice of tick source. Further sequences cover an external acquisition closed by a second write, an abort in mid-conversion, a conversion stalled by a high chip select, both power-down codes, and a write while the interrupt is pending.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    // Conversion progress
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQI = 2'd1,
        PH_ACQX = 2'd2,
        PH_CONV = 2'd3
    } phase_t;

    // Power state reported to analog blocks
    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_STBY = 2'd1,
        PWR_OFF  = 2'd2
    } pwr_t;

    // Bit positions inside the control byte
    localparam int CB_PWR_HI = 7;
    localparam int CB_PWR_LO = 6;
    localparam int CB_ACQX   = 5;
    localparam int CB_SINGLE = 4;
    localparam int CB_UNI    = 3;
    localparam int CB_ADDR_W = 3;

endpackage

// File: rtl/adcseq_strobe.sv
module adcseq_strobe #(
    parameter int INT_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic conv_clk,
    input  logic ext_mode,
    output logic wr_evt,
    output logic rd_evt,
    output logic tick
);
    localparam int DW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;

    typedef struct packed {
        logic          wr_prev;
        logic          rd_prev;
        logic          ck_prev;
        logic [DW-1:0] div;
    } strobe_t;

    strobe_t s_d, s_q;
    logic    int_tick;
    logic    ext_tick;

    always_comb begin
        s_d         = s_q;
        s_d.wr_prev = wr_n;
        s_d.rd_prev = rd_n;
        s_d.ck_prev = conv_clk;
        if (s_q.div == DW'(INT_DIV - 1)) begin
            s_d.div = '0;
        end else begin
            s_d.div = s_q.div + DW'(1);
        end
        int_tick = (s_q.div == DW'(INT_DIV - 1));
        ext_tick = !cs_n && s_q.ck_prev && !conv_clk;
        wr_evt   = !cs_n && !s_q.wr_prev && wr_n;
        rd_evt   = !cs_n && s_q.rd_prev && !rd_n;
        tick     = ext_mode ? ext_tick : int_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{wr_prev: 1'b1, rd_prev: 1'b1, ck_prev: 1'b0, div: '0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/adcseq_sar.sv
module adcseq_sar #(
    parameter int W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 step,
    input  logic [$clog2(W)-1:0] idx,
    input  logic                 cmp,
    output logic [W-1:0]         code
);
    localparam int IW = $clog2(W);

    logic [W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (start) begin
            code_d = {1'b1, {(W-1){1'b0}}};
        end else if (step) begin
            code_d[idx] = cmp;
            if (idx != '0) begin
                code_d[idx - IW'(1)] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code = code_q;

endmodule

// File: rtl/adcseq_fmt.sv
module adcseq_fmt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         uni,
    input  logic [W-1:0] code,
    input  logic         hben,
    output logic [7:0]   dout
);
    localparam int BW = 8;
    localparam int HW = W - BW;
    localparam int FW = BW - HW;

    typedef struct packed {
        logic [W-1:0] res;
        logic         uni;
    } fmt_t;

    fmt_t f_d, f_q;
    logic fill;

    always_comb begin
        f_d = f_q;
        if (capture) begin
            f_d.uni = uni;
            if (uni) begin
                f_d.res = code;
            end else begin
                f_d.res = {~code[W-1], code[W-2:0]};
            end
        end
        fill = f_q.uni ? 1'b0 : f_q.res[W-1];
        if (hben) begin
            dout = {{FW{fill}}, f_q.res[W-1:BW]};
        end else begin
            dout = f_q.res[BW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{res: '0, uni: 1'b1};
        end else begin
            f_q <= f_d;
        end
    end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int CONV_TICKS = 13,
    parameter int ACQ_TICKS  = 3,
    parameter int INT_DIV    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             hben,
    input  logic [7:0]       din,
    input  logic             conv_clk,
    input  logic             cmp_in,
    output logic [7:0]       dout,
    output logic             dout_en,
    output logic             int_n,
    output logic [RES_W-1:0] dac_code,
    output logic             track,
    output logic [2:0]       chan_sel,
    output logic             diff_mode,
    output logic             pair_swap,
    output logic             ext_clk_mode,
    output logic [1:0]       pwr_state
);
    localparam int CMAX = (CONV_TICKS > ACQ_TICKS) ? CONV_TICKS : ACQ_TICKS;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int IW   = $clog2(RES_W);

    typedef struct packed {
        phase_t                 phase;
        logic [CW-1:0]          cnt;
        logic [1:0]             pd;
        logic                   single;
        logic                   uni;
        logic [CB_ADDR_W-1:0]   addr;
        logic                   ext_mode;
        logic                   int_n;
        pwr_t                   pwr;
    } seq_t;

    seq_t r_d, r_q;

    logic          wr_evt;
    logic          rd_evt;
    logic          tick;
    logic          sar_start;
    logic          sar_step;
    logic          res_cap;
    logic [IW-1:0] sar_idx;
    logic [6:0]    cfg_q;
    phase_t        phase_q;

    adcseq_strobe #(.INT_DIV(INT_DIV)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .conv_clk (conv_clk),
        .ext_mode (r_q.ext_mode),
        .wr_evt   (wr_evt),
        .rd_evt   (rd_evt),
        .tick     (tick)
    );

    always_comb begin
        r_d       = r_q;
        sar_start = 1'b0;
        sar_step  = 1'b0;
        res_cap   = 1'b0;
        sar_idx   = IW'(RES_W - 1) - IW'(r_q.cnt);
        if (wr_evt) begin
            r_d.pd     = din[CB_PWR_HI:CB_PWR_LO];
            r_d.single = din[CB_SINGLE];
            r_d.uni    = din[CB_UNI];
            r_d.addr   = din[CB_ADDR_W-1:0];
            r_d.int_n  = 1'b1;
            r_d.pwr    = PWR_ON;
            r_d.cnt    = '0;
            if (din[CB_PWR_HI]) begin
                r_d.ext_mode = din[CB_PWR_LO];
            end
            if (din[CB_ACQX]) begin
                r_d.phase = PH_ACQX;
            end else if (r_q.phase == PH_ACQX) begin
                r_d.phase = PH_CONV;
                sar_start = 1'b1;
            end else begin
                r_d.phase = PH_ACQI;
            end
        end else begin
            if (rd_evt) begin
                r_d.int_n = 1'b1;
            end
            if (tick) begin
                case (r_q.phase)
                    PH_ACQI: begin
                        if (r_q.cnt == CW'(ACQ_TICKS)) begin
                            r_d.phase = PH_CONV;
                            r_d.cnt   = '0;
                            sar_start = 1'b1;
                        end else begin
                            r_d.cnt = r_q.cnt + CW'(1);
                        end
                    end
                    PH_CONV: begin
                        if (r_q.cnt < CW'(RES_W)) begin
                            sar_step = 1'b1;
                        end
                        if (r_q.cnt == CW'(CONV_TICKS - 1)) begin
                            r_d.phase = PH_IDLE;
                            r_d.cnt   = '0;
                            r_d.int_n = 1'b0;
                            res_cap   = 1'b1;
                            if (r_q.pd[1]) begin
                                r_d.pwr = PWR_ON;
                            end else if (r_q.pd[0]) begin
                                r_d.pwr = PWR_STBY;
                            end else begin
                                r_d.pwr = PWR_OFF;
                            end
                        end else begin
                            r_d.cnt = r_q.cnt + CW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, cnt: '0, pd: 2'b11, single: 1'b1, uni: 1'b1,
                     addr: '0, ext_mode: 1'b1, int_n: 1'b1, pwr: PWR_ON};
        end else begin
            r_q <= r_d;
        end
    end

    adcseq_sar #(.W(RES_W)) u_sar (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sar_start),
        .step  (sar_step),
        .idx   (sar_idx),
        .cmp   (cmp_in),
        .code  (dac_code)
    );

    adcseq_fmt #(.W(RES_W)) u_fmt (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (res_cap),
        .uni     (r_q.uni),
        .code    (dac_code),
        .hben    (hben),
        .dout    (dout)
    );

    assign dout_en      = !cs_n && !rd_n;
    assign int_n        = r_q.int_n;
    assign track        = (r_q.phase == PH_ACQI) || (r_q.phase == PH_ACQX);
    assign chan_sel     = r_q.addr;
    assign diff_mode    = !r_q.single;
    assign pair_swap    = !r_q.single && r_q.addr[0];
    assign ext_clk_mode = r_q.ext_mode;
    assign pwr_state    = r_q.pwr;
    assign cfg_q        = {r_q.pd, r_q.single, r_q.uni, r_q.addr};
    assign phase_q      = r_q.phase;

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk
    import adcseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       track,
    input logic       int_n,
    input logic       ext_clk_mode,
    input logic [1:0] pwr_state,
    input logic       wr_evt,
    input logic [6:0] cfg_q,
    input phase_t     phase_q
);

    // R2: deselected cycles never change the stored configuration
    p_cs_blocks_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(cfg_q));

    // R3: tick source changes only through an accepted write
    p_clk_mode_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext_clk_mode) |-> $past(wr_evt));

    // R4: tracking begins only after a write
    p_track_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(track) |-> $past(wr_evt));

    // R6: interrupt falls only at the end of a conversion
    p_int_from_conv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $past(phase_q == PH_CONV));

    // R9: an accepted write releases the interrupt
    p_write_clears_int_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> int_n);

    // R13: powered-down states occur only while idle
    p_sleep_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != PWR_ON) |-> (phase_q == PH_IDLE));

endmodule

bind adcseq_top adcseq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .track        (track),
    .int_n        (int_n),
    .ext_clk_mode (ext_clk_mode),
    .pwr_state    (pwr_state),
    .wr_evt       (wr_evt),
    .cfg_q        (cfg_q),
    .phase_q      (phase_q)
);

// File: tb/sim_adcseq_top.sv
`timescale 1ns/1ps
module sim_adcseq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, hben = 1'b0;
    logic [7:0] din = 8'h00;
    logic       conv_clk = 1'b0;
    logic       cmp_in;
    logic [7:0] dout;
    logic       dout_en, int_n, track, diff_mode, pair_swap, ext_clk_mode;
    logic [9:0] dac_code;
    logic [2:0] chan_sel;
    logic [1:0] pwr_state;

    int target = 0;
    int nchk = 0;
    int nfail = 0;
    bit armed = 0;

    always #5 clk = ~clk;

    // comparator emulation: input at or above trial code keeps the bit
    assign cmp_in = (target >= int'(dac_code));

    adcseq_top u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .hben(hben), .din(din), .conv_clk(conv_clk), .cmp_in(cmp_in),
        .dout(dout), .dout_en(dout_en), .int_n(int_n), .dac_code(dac_code),
        .track(track), .chan_sel(chan_sel), .diff_mode(diff_mode),
        .pair_swap(pair_swap), .ext_clk_mode(ext_clk_mode), .pwr_state(pwr_state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // external conversion clock: period of four system clocks
    int ckdiv = 0;
    always @(negedge clk) begin
        #1;
        ckdiv = ckdiv + 1;
        if (ckdiv == 2) begin
            ckdiv = 0;
            conv_clk = ~conv_clk;
        end
    end

    // ---------------- behavioural reference ----------------
    int m_ctrl, m_ext, m_int, m_pwr, m_ph, m_cnt, m_sar, m_res, m_resuni, m_div;
    int p_wr, p_rd, p_ck;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 8'hD8; m_ext = 1; m_int = 1; m_pwr = 0; m_ph = 0; m_cnt = 0;
            m_sar = 0; m_res = 0; m_resuni = 1; m_div = 0;
            p_wr = 1; p_rd = 1; p_ck = 0;
        end else begin
            bit wr_e, rd_e, tk;
            int b;
            wr_e = !cs_n && (p_wr == 0) && wr_n;
            rd_e = !cs_n && (p_rd == 1) && !rd_n;
            tk   = m_ext ? (!cs_n && (p_ck == 1) && !conv_clk) : (m_div == 3);
            m_div = (m_div + 1) % 4;
            p_wr = wr_n; p_rd = rd_n; p_ck = conv_clk;
            if (wr_e) begin
                m_ctrl = din; m_int = 1; m_pwr = 0; m_cnt = 0;
                if (din[7]) m_ext = din[6];
                if (din[5]) m_ph = 2;
                else if (m_ph == 2) begin m_ph = 3; m_sar = 512; end
                else m_ph = 1;
            end else begin
                if (rd_e) m_int = 1;
                if (tk && m_ph == 1) begin
                    if (m_cnt == 3) begin m_ph = 3; m_cnt = 0; m_sar = 512; end
                    else m_cnt++;
                end else if (tk && m_ph == 3) begin
                    if (m_cnt < 10) begin
                        b = 9 - m_cnt;
                        if (target < m_sar) m_sar = m_sar & ~(1 << b);
                        if (b > 0) m_sar = m_sar | (1 << (b - 1));
                    end
                    if (m_cnt == 12) begin
                        m_ph = 0; m_cnt = 0; m_int = 0;
                        m_resuni = (m_ctrl >> 3) & 1;
                        m_res = m_resuni ? m_sar : (m_sar ^ 512);
                        if (m_ctrl[7]) m_pwr = 0;
                        else m_pwr = m_ctrl[6] ? 1 : 2;
                    end else m_cnt++;
                end
            end
        end
    end

    function automatic int exp_byte(input int hi);
        int fill;
        fill = m_resuni ? 0 : ((m_res >> 9) & 1);
        if (hi) return (fill ? 8'hFC : 0) | ((m_res >> 8) & 3);
        return m_res & 255;
    endfunction

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && armed) begin
            chk("R6 int_n", int_n, m_int);
            chk("R4 track", track, (m_ph == 1 || m_ph == 2) ? 1 : 0);
            chk("R3 ext_clk_mode", ext_clk_mode, m_ext);
            chk("R13 pwr_state", pwr_state, m_pwr);
            chk("R14 chan_sel", chan_sel, m_ctrl & 7);
            chk("R14 diff_mode", diff_mode, ((m_ctrl >> 4) & 1) ? 0 : 1);
            chk("R14 pair_swap", pair_swap, (!((m_ctrl >> 4) & 1) && (m_ctrl & 1)) ? 1 : 0);
            chk("R7 dac_code", dac_code, m_sar);
            chk("R12 dout_en", dout_en, (!cs_n && !rd_n) ? 1 : 0);
            if (dout_en) chk("R10 dout", dout, exp_byte(hben));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] b);
        @(negedge clk); #1;
        cs_n = 1'b0; din = b; wr_n = 1'b0;
        @(negedge clk); #1;
        wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic hi, output int val);
        @(negedge clk); #1;
        cs_n = 1'b0; hben = hi; rd_n = 1'b0;
        @(negedge clk);
        val = dout;
        #1 rd_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int v;
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        armed = 1;
        // R1 reset state
        chk("R1 int_n", int_n, 1);
        chk("R1 ext_clk_mode", ext_clk_mode, 1);
        chk("R1 pwr_state", pwr_state, 0);
        chk("R1 track", track, 0);
        chk("R1 chan_sel", chan_sel, 0);
        chk("R1 dout_en", dout_en, 0);

        // R2: strobe with chip select high is ignored
        #1 din = 8'h85; wr_n = 1'b0;
        @(negedge clk); #1 wr_n = 1'b1;
        wait_cyc(3);
        chk("R2 track", track, 0);
        chk("R2 chan_sel", chan_sel, 0);

        // A: external tick, internal acquisition, unipolar, ch5, target 700
        target = 700;
        bus_write(8'hDD);
        wait_cyc(2);
        chk("R4 track after write", track, 1);
        chk("R14 chan_sel", chan_sel, 5);
        wait_cyc(90);
        chk("R6 int_n low", int_n, 0);
        bus_read(1'b0, v); chk("R10 low byte", v, 8'hBC);
        wait_cyc(1);
        chk("R9 int_n after read", int_n, 1);
        bus_read(1'b1, v); chk("R10 high byte", v, 8'h02);

        // B: internal tick, bipolar, differential pair swap, target 300
        target = 300;
        bus_write(8'h83);
        wait_cyc(2);
        chk("R3 internal tick", ext_clk_mode, 0);
        chk("R14 pair_swap", pair_swap, 1);
        wait_cyc(90);
        bus_read(1'b1, v); chk("R11 bipolar high byte", v, 8'hFF);
        bus_read(1'b0, v); chk("R11 bipolar low byte", v, 8'h2C);

        // E: power-down codes
        target = 512;
        bus_write(8'h1D);
        wait_cyc(2);
        chk("R3 mode kept on power code", ext_clk_mode, 0);
        wait_cyc(90);
        chk("R13 full off", pwr_state, 2);
        bus_read(1'b0, v); chk("R13 read while off", v, 0);
        bus_write(8'h5D);
        wait_cyc(2);
        chk("R13 wake on write", pwr_state, 0);
        wait_cyc(90);
        chk("R13 standby", pwr_state, 1);

        // C: external acquisition closed by second write
        target = 123;
        bus_write(8'hFD);
        wait_cyc(40);
        chk("R5 open acquisition", track, 1);
        bus_write(8'hDD);
        wait_cyc(2);
        chk("R5 conversion started", track, 0);
        wait_cyc(70);
        bus_read(1'b0, v); chk("R5 result low", v, 123);

        // D: abort mid-conversion
        target = 1000;
        bus_write(8'hDD);
        wait_cyc(30);
        target = 77;
        bus_write(8'hDD);
        wait_cyc(90);
        bus_read(1'b0, v); chk("R8 restarted result", v, 77);
        bus_read(1'b1, v); chk("R8 restarted high", v, 0);

        // stall: chip select high blocks external ticks
        target = 400;
        bus_write(8'hDD);
        @(negedge clk); #1 cs_n = 1'b1;
        wait_cyc(100);
        chk("R12 stalled int_n", int_n, 1);
        #1 rd_n = 1'b0;
        @(negedge clk);
        chk("R12 no drive when deselected", dout_en, 0);
        #1 rd_n = 1'b1; cs_n = 1'b0;
        wait_cyc(90);
        chk("R12 resumed int_n", int_n, 0);
        bus_read(1'b0, v); chk("R10 low 400", v, 144);
        bus_read(1'b1, v); chk("R10 high 400", v, 1);

        // R9: write clears pending interrupt
        target = 5;
        bus_write(8'hDD);
        wait_cyc(90);
        chk("R9 pending", int_n, 0);
        bus_write(8'hFD);
        wait_cyc(2);
        chk("R9 cleared by write", int_n, 1);

        wait_cyc(5);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule